// File: doc/BRIEF.md
# FIFO-Buffered Serial Peripheral Interface Master

This block is a register-mapped serial master that moves frames of 4 to 16 bits between two eight-entry FIFOs and a three-wire serial port (serial clock, data out, data in). Software loads the transmit FIFO through a data register. The engine then sends frames back to back, most significant bit first, while it collects the same number of bits from the data input into the receive FIFO. Frame length, clock polarity, clock phase and bit rate are set in a control register. A prescale register and a rate field set the bit rate together.

Three level-sensitive interrupt outputs report a well-filled receive FIFO, a draining transmit FIFO and a lost receive frame. A loopback mode feeds the outgoing data straight back into the receiver. Chip select is handled outside the block. The slave-related control bits are stored but have no effect.

The register bus is a single-cycle access port. `bus_en` with `bus_we` high writes `bus_wdata`. `bus_rdata` always shows the register selected by `bus_addr`. A read access (`bus_en` high, `bus_we` low) to the data register removes the head entry of the receive FIFO. Word offsets are: 0x00 format, 0x04 control, 0x08 data, 0x0C status, 0x10 prescale, 0x14 interrupt status (writing to 0x14 clears).

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, format (0x00) and control (0x04) read 0, prescale (0x10) reads 2, status (0x0C) reads 0x03, interrupt status (0x14) reads 0, and `sclk` and `mosi` are low.
- R2: Format bits [3:0] hold frame length minus one, and values 0 to 2 give 4-bit frames. Frames are sent and received most significant bit first, taken from the low bits of the data written. A received frame reads back zero-extended in the low bits.
- R3: One serial clock period lasts prescale × (1 + rate) input clock cycles, where rate is format bits [15:8]. Prescale bit 0 always reads 0, and a stored prescale of 0 behaves as 2.
- R4: `sclk` idles at format bit 7 (polarity). With format bit 6 (phase) at 0, each bit is sampled on the edge leaving idle. With bit 6 at 1, each bit is sampled on the edge returning to idle. Both directions are checked against an external device.
- R5: With control bit 3 (loopback) set, the receiver takes the outgoing data and ignores `miso`.
- R6: The transmit FIFO holds 8 frames, and a data write while it is full is dropped. Status bits are: 0 transmit empty, 1 transmit not full, 2 receive not empty, 3 receive full, 4 busy.
- R7: A data read removes one received frame. A read of an empty receive FIFO returns 0 and changes nothing.
- R8: `irq_rx` and interrupt status bit 0 are high when control bit 0 is set and the receive FIFO holds at least 4 frames.
- R9: `irq_tx` and interrupt status bit 1 are high when control bit 1 is set and the transmit FIFO holds at most 4 frames.
- R10: A frame that completes while the receive FIFO is full is discarded, and an overrun flag is set. When control bit 2 is set, the flag shows on `irq_ovr` and on interrupt status bit 2. Any write to 0x14 clears it.
- R11: Clearing control bit 4 (enable) stops shifting at once and returns `sclk` to idle. The frame in flight is abandoned, and the frames still in both FIFOs are kept.
- R12: Control bits 5 and 6 are stored and read back but change no behaviour.
- R13: Busy (status bit 4) is high while a frame is in flight or the transmit FIFO is not empty. Queued frames follow each other with no gap in the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq_rx | output | 1 | Receive level interrupt |
| irq_tx | output | 1 | Transmit level interrupt |
| irq_ovr | output | 1 | Receive overrun interrupt |

## Verification
Random runs pick polarity, phase, frame length, prescale and rate. Each run exchanges a random frame burst with a bench slave that samples only on the edge the mode defines, so a mode or bit-order error shows up as corrupted data in one direction. The spacing of serial clock edges across frame boundaries tells correct division apart from off-by-one timing and from gaps between frames. Directed loopback cases with a hostile slave driving `miso` check three things: that the loopback path really bypasses `miso`; the exact interrupt thresholds (3 against 4, 4 against 5 entries); and overrun with drop-oldest versus drop-newest behaviour. A mid-frame disable separates abandoning the shifter from flushing the FIFOs.

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DEPTH = 8,
  parameter int FW    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        irq_rx,
  output logic        irq_tx,
  output logic        irq_ovr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int HW = $clog2(2 * FW) + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  logic [15:0] fmt;
  logic [6:0]  ctl;
  logic [7:0]  presc;
  logic        ovr;

  wire [3:0] dss   = fmt[3:0];
  wire       cpha  = fmt[6];
  wire       cpol  = fmt[7];
  wire [7:0] rate  = fmt[15:8];
  wire       port_en = ctl[4];
  wire       lbm   = ctl[3];

  wire wr      = bus_en & bus_we;
  wire wr_fmt  = wr & (bus_addr == 5'h00);
  wire wr_ctl  = wr & (bus_addr == 5'h04);
  wire wr_dat  = wr & (bus_addr == 5'h08);
  wire wr_psc  = wr & (bus_addr == 5'h10);
  wire wr_icr  = wr & (bus_addr == 5'h14);
  wire rd_dat  = bus_en & ~bus_we & (bus_addr == 5'h08);

  logic [FW-1:0] tx_mem [DEPTH];
  logic [FW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  logic          active;
  logic [HW-1:0] h;
  logic [15:0]   div_cnt;
  logic [FW-1:0] sh, rx_sh;

  wire [4:0]    nbits    = (dss < 4'd3) ? 5'd4 : {1'b0, dss} + 5'd1;
  wire [HW-1:0] last_h   = HW'({nbits, 1'b0}) - HW'(1);
  wire [6:0]    pre      = (presc[7:1] == 7'd0) ? 7'd1 : presc[7:1];
  wire [15:0]   half_len = 16'(pre) * (16'(rate) + 16'd1);
  wire          half_end = active & (div_cnt == half_len - 16'd1);
  wire          frame_done = port_en & half_end & (h == last_h);
  wire          start    = port_en & (tx_cnt != '0) & (~active | frame_done);
  wire          din      = lbm ? mosi : miso;

  wire tx_push = wr_dat & (tx_cnt != FULL);
  wire tx_pop  = start;
  wire rx_push = frame_done & (rx_cnt != FULL);
  wire ovr_set = frame_done & (rx_cnt == FULL);
  wire rx_pop  = rd_dat & (rx_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt   <= '0;
      ctl   <= '0;
      presc <= 8'd2;
      ovr   <= 1'b0;
    end else begin
      if (wr_fmt) fmt   <= bus_wdata[15:0];
      if (wr_ctl) ctl   <= bus_wdata[6:0];
      if (wr_psc) presc <= {bus_wdata[7:1], 1'b0};
      if (ovr_set)     ovr <= 1'b1;
      else if (wr_icr) ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[FW-1:0];
    if (rx_push) rx_mem[rx_wp] <= rx_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + AW'(1);
      if (tx_pop)  tx_rp <= tx_rp + AW'(1);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (rx_push) rx_wp <= rx_wp + AW'(1);
      if (rx_pop)  rx_rp <= rx_rp + AW'(1);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      h       <= '0;
      div_cnt <= '0;
      sh      <= '0;
      rx_sh   <= '0;
    end else if (!port_en) begin
      active <= 1'b0;
    end else if (start) begin
      active  <= 1'b1;
      h       <= '0;
      div_cnt <= '0;
      sh      <= tx_mem[tx_rp] << (FW - int'(nbits));
      rx_sh   <= '0;
    end else if (frame_done) begin
      active <= 1'b0;
    end else if (active) begin
      if (half_end) begin
        div_cnt <= '0;
        h       <= h + HW'(1);
        if (!h[0]) rx_sh <= {rx_sh[FW-2:0], din};
        else       sh    <= sh << 1;
      end else begin
        div_cnt <= div_cnt + 16'd1;
      end
    end
  end

  assign sclk = active ? (cpol ^ h[0] ^ cpha) : cpol;
  assign mosi = active & sh[FW-1];

  wire       busy = active | (tx_cnt != '0);
  wire [4:0] stat = {busy, rx_cnt == FULL, rx_cnt != '0, tx_cnt != FULL, tx_cnt == '0};

  assign irq_rx  = ctl[0] & (rx_cnt >= HALF);
  assign irq_tx  = ctl[1] & (tx_cnt <= HALF);
  assign irq_ovr = ctl[2] & ovr;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      5'h00: bus_rdata = {16'd0, fmt};
      5'h04: bus_rdata = {25'd0, ctl};
      5'h08: bus_rdata = (rx_cnt != '0) ? 32'(rx_mem[rx_rp]) : 32'd0;
      5'h0C: bus_rdata = {27'd0, stat};
      5'h10: bus_rdata = {24'd0, presc};
      5'h14: bus_rdata = {29'd0, irq_ovr, irq_tx, irq_rx};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          port_en,
  input logic          cpol,
  input logic          sclk,
  input logic          active,
  input logic          frame_done,
  input logic          wr_dat,
  input logic          wr_icr,
  input logic          rd_dat,
  input logic          tx_pop,
  input logic          ovr,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  // R6
  tx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && tx_cnt == CW'(DEPTH) && !tx_pop) |=> tx_cnt == CW'(DEPTH));
  // R10
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_cnt == CW'(DEPTH)) |=> ovr);
  // R10
  ovr_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_cnt == CW'(DEPTH) && !rd_dat) |=> rx_cnt == CW'(DEPTH));
  // R10
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_icr && !(frame_done && rx_cnt == CW'(DEPTH))) |=> !ovr);
  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat && rx_cnt == '0 && !frame_done) |=> rx_cnt == '0);
  // R11
  idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && $past(!port_en)) |-> sclk == cpol);
  // R13
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && tx_cnt != '0) |=> active);
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .cpol(cpol), .sclk(sclk),
  .active(active), .frame_done(frame_done), .wr_dat(wr_dat), .wr_icr(wr_icr),
  .rd_dat(rd_dat), .tx_pop(tx_pop), .ovr(ovr), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb;
  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic sclk, mosi, miso, irq_rx, irq_tx, irq_ovr;

  spi_fifo_master u_dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errs = 0;
  bit done = 0;

  logic s_cpol = 0, s_cpha = 0;
  int s_nb = 8, s_in_n = 0, s_out_i = 0, s_bit = 0, cyc = 0, rise_n = 0;
  logic [15:0] s_out [16];
  logic [15:0] s_in [16];
  logic [15:0] s_acc = 0;
  logic prev_sclk = 0;
  int rise_t [8];

  assign miso = (s_bit < s_nb) ? s_out[s_out_i & 15][s_nb-1-s_bit] : 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (sclk !== prev_sclk) begin
      if (sclk && rise_n < 8) begin rise_t[rise_n] = cyc; rise_n++; end
      if (sclk == (s_cpol ^ !s_cpha)) begin
        s_acc = {s_acc[14:0], mosi};
        s_bit++;
        if (s_bit == s_nb) begin
          s_in[s_in_n & 15] = s_acc;
          s_in_n++; s_bit = 0; s_acc = 0; s_out_i++;
        end
      end
    end
    prev_sclk = sclk;
  end

  function automatic logic [15:0] fmask(int nb);
    return 16'((32'h1 << nb) - 1);
  endfunction

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 0; bus_en = 1;
    #1 d = bus_rdata;
    @(negedge clk); bus_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  task automatic slave_reset(input logic cp, input logic ph, input int nb);
    @(negedge clk);
    s_cpol = cp; s_cpha = ph; s_nb = nb;
    s_in_n = 0; s_out_i = 0; s_bit = 0; s_acc = 0; rise_n = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    do rd(5'h0C, st); while (st[4]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] txd [9];
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 16; i++) s_out[i] = 16'hFFFF;
    do_reset();

    // R1 reset state
    rd(5'h00, v); chk("R1 fmt", v, 0);
    rd(5'h04, v); chk("R1 ctl", v, 0);
    rd(5'h10, v); chk("R1 presc", v, 2);
    rd(5'h0C, v); chk("R1 status", v, 32'h03);
    rd(5'h14, v); chk("R1 irq", v, 0);
    chk("R1 pins", {sclk, mosi}, 0);

    // R2 R4 R3 R13 random exchanges with external slave
    for (int it = 0; it < 8; it++) begin
      logic cp, ph; int dss, nb, pre, scr, n;
      do_reset();
      cp = 1'($urandom % 2); ph = 1'($urandom % 2);
      dss = 3 + $urandom % 13; nb = dss + 1;
      pre = 2 * (1 + $urandom % 3); scr = $urandom % 4; n = 1 + $urandom % 8;
      wr(5'h00, {16'd0, 8'(scr), cp, ph, 2'b00, 4'(dss)});
      wr(5'h10, pre);
      slave_reset(cp, ph, nb);
      for (int k = 0; k < 16; k++) s_out[k] = 16'($urandom);
      for (int k = 0; k < n; k++) begin txd[k] = 16'($urandom); wr(5'h08, txd[k]); end
      wr(5'h04, 32'h10);
      wait_idle();
      chk("R4 slave frame count", s_in_n, n);
      for (int k = 0; k < n; k++) chk("R2 R4 master-to-slave", s_in[k] & fmask(nb), txd[k] & fmask(nb));
      for (int k = 0; k < n; k++) begin rd(5'h08, v); chk("R2 R4 slave-to-master", v, s_out[k] & fmask(nb)); end
      chk("R4 idle level", sclk, cp);
      if (rise_n >= 4) chk("R3 R13 clock period", rise_t[3] - rise_t[2], pre * (1 + scr));
    end
    for (int i = 0; i < 16; i++) s_out[i] = 16'hFFFF;

    // R3 prescale encoding
    do_reset();
    wr(5'h10, 5); rd(5'h10, v); chk("R3 prescale bit0", v, 4);
    wr(5'h10, 0); rd(5'h10, v); chk("R3 prescale zero", v, 0);
    wr(5'h00, 32'h0107);
    slave_reset(0, 0, 8);
    wr(5'h08, 8'h3C); wr(5'h08, 8'hC3); wr(5'h04, 32'h18);
    wait_idle();
    chk("R3 zero acts as two", rise_t[3] - rise_t[2], 4);

    // R2 R5 short frames in loopback with miso held high
    do_reset();
    wr(5'h00, 32'h0001); wr(5'h04, 32'h18);
    wr(5'h08, 16'hABCD); wait_idle(); rd(5'h08, v); chk("R2 R5 dss1 four bits", v, 4'hD);
    wr(5'h00, 32'h0000);
    wr(5'h08, 16'h0002); wait_idle(); rd(5'h08, v); chk("R2 R5 dss0 four bits", v, 4'h2);
    wr(5'h00, 32'h000F);
    wr(5'h08, 16'h1234); wait_idle(); rd(5'h08, v); chk("R5 loopback 16 bit", v, 16'h1234);

    // R12 slave bits stored, no effect
    do_reset();
    wr(5'h00, 32'h0007); wr(5'h04, 32'hF8);
    rd(5'h04, v); chk("R12 readback", v, 32'h78);
    wr(5'h08, 8'h5A); wait_idle(); rd(5'h08, v); chk("R12 no effect", v, 8'h5A);

    // R8 receive threshold
    do_reset();
    wr(5'h00, 32'h0007); wr(5'h04, 32'h19);
    for (int k = 0; k < 3; k++) wr(5'h08, 8'h10 + k);
    wait_idle(); chk("R8 three below", irq_rx, 0);
    rd(5'h14, v); chk("R8 status three", v, 0);
    wr(5'h08, 8'h13); wait_idle(); chk("R8 four at", irq_rx, 1);
    rd(5'h14, v); chk("R8 status four", v, 1);

    // R9 R6 R7 transmit threshold and full drop
    do_reset();
    wr(5'h04, 32'h02);
    chk("R9 empty", irq_tx, 1);
    for (int k = 0; k < 4; k++) begin txd[k] = 16'($urandom); wr(5'h08, txd[k]); end
    chk("R9 four", irq_tx, 1);
    txd[4] = 16'($urandom); wr(5'h08, txd[4]);
    chk("R9 five", irq_tx, 0);
    rd(5'h14, v); chk("R9 status five", v, 0);
    for (int k = 5; k < 9; k++) begin txd[k] = 16'($urandom); wr(5'h08, txd[k]); end
    rd(5'h0C, v); chk("R6 full status", v, 32'h10);
    wr(5'h00, 32'h000F); wr(5'h04, 32'h1A);
    wait_idle();
    for (int k = 0; k < 8; k++) begin rd(5'h08, v); chk("R6 first eight kept", v, txd[k]); end
    rd(5'h08, v); chk("R7 empty read zero", v, 0);
    rd(5'h0C, v); chk("R6 R7 drained status", v, 32'h03);

    // R10 overrun
    do_reset();
    wr(5'h00, 32'h0007); wr(5'h04, 32'h1C);
    for (int k = 0; k < 8; k++) wr(5'h08, 8'hA0 + k);
    wait_idle();
    rd(5'h14, v); chk("R10 no overrun at full", v, 0);
    wr(5'h08, 8'h55); wr(5'h08, 8'h66); wait_idle();
    rd(5'h14, v); chk("R10 overrun flag", v, 4);
    chk("R10 overrun pin", irq_ovr, 1);
    rd(5'h0C, v); chk("R10 full status", v, 32'h0F);
    wr(5'h14, 0);
    rd(5'h14, v); chk("R10 cleared", v, 0);
    for (int k = 0; k < 8; k++) begin rd(5'h08, v); chk("R10 oldest kept", v, 8'hA0 + k); end

    // R11 disable mid-frame
    do_reset();
    wr(5'h00, 32'h0987); wr(5'h10, 20);
    wr(5'h08, 8'hA1); wr(5'h08, 8'hB2); wr(5'h08, 8'hC3);
    wr(5'h04, 32'h18);
    repeat (300) @(negedge clk);
    wr(5'h04, 32'h08);
    repeat (3) @(negedge clk);
    chk("R11 sclk idle", sclk, 1);
    rd(5'h0C, v); chk("R11 FIFOs kept", v, 32'h12);
    wr(5'h04, 32'h18);
    wait_idle();
    rd(5'h08, v); chk("R11 second frame", v, 8'hB2);
    rd(5'h08, v); chk("R11 third frame", v, 8'hC3);
    rd(5'h0C, v); chk("R11 R13 idle status", v, 32'h03);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule